// File: doc/BRIEF.md
# Packed/Zoned Decimal Converter

This block turns a stream of zoned decimal bytes into packed decimal, or a packed stream back into zoned bytes. Each frame is one signed decimal number. Bytes travel least significant first, and a marker flags the most significant byte. Input and output both use a valid/ready handshake. The direction select chooses packing or unpacking, and a character-set bit chooses the zone nibble written on unpacked output.

A zoned byte holds a zone in its upper nibble and a digit in its lower nibble. The zone of the least significant byte gives the sign. Packing places two digits in each byte and moves the sign into the lowest nibble of the frame, using the generated codes 1100 for plus and 1101 for minus. Unpacking reverses this. Non-sign bytes get zone 0011 in ASCII mode and 1111 in EBCDIC mode. A digit nibble above nine is passed through, and the output byte that carries it is flagged.

The output is registered, so an output byte appears one cycle after the input byte that produced it. Direction and mode are taken from the first byte of a frame and are held until that frame's final byte has been consumed.

Top module: `dec_conv`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1 (with out_ready_i high).
- R2: When packing, the first (least significant) input byte yields the packed byte {digit, sign}. The sign is 1101 if its zone is 1101 or 1011, and 1100 for any other zone.
- R3: When packing, the later digits are paired. Each packed byte is {later digit in bits 7:4, earlier digit in bits 3:0}.
- R4: When packing, if a frame's last byte leaves one digit unpaired (even digit count), the final packed byte is {0000, digit}.
- R5: out_last_o is 1 on the final output byte of a frame and 0 on every other output byte.
- R6: When unpacking, the first packed byte {d, s} yields the zoned byte {s, d}. The packed sign nibble becomes the zone.
- R7: When unpacking, each later packed byte {h, l} yields two zoned bytes, first {z, l} and then {z, h}. The zone z is 0011 when ebcdic_i=0 and 1111 when ebcdic_i=1. A frame of N packed bytes therefore gives 2N-1 output bytes.
- R8: dir_i (0 = pack, 1 = unpack) and ebcdic_i are taken at a frame's first byte. Changes to them during the frame have no effect on that frame's output.
- R9: The mode bit ebcdic_i has no effect on packed output.
- R10: out_err_o is 1 exactly when an output byte carries a digit nibble above 1001.
- R11: While out_valid_o=1 and out_ready_i=0, the output byte, last and err flags hold steady. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0 = pack zoned input, 1 = unpack packed input |
| ebcdic_i | input | 1 | Zone set for unpacked output: 0 ASCII, 1 EBCDIC |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the most significant (final) byte of a frame |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream can take the output byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final output byte of a frame |
| out_err_o | output | 1 | Output byte carries a digit above nine |

## Verification
Most of the state is a few flags per frame, so a wrong flag shows up at the ports within one or two output bytes. If the packer's pending-digit flag sticks, the next packed byte gets the wrong nibble or the pad is missing. If a frame-start flag is wrong, the sign lands in a digit position of the next frame's first output byte. If the unpacker's nibble phase is wrong, the output count changes from 2N-1, and the bench sees this as a length mismatch as soon as the frame ends. Back-pressure patterns expose any output register that changes or drops a byte while stalled.

// File: rtl/dec_conv_pkg.sv
package dec_conv_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;

  localparam logic [NIB_W-1:0] SIGN_PLUS   = 4'hC;
  localparam logic [NIB_W-1:0] SIGN_MINUS  = 4'hD;
  localparam logic [NIB_W-1:0] SIGN_MINUS2 = 4'hB;
  localparam logic [NIB_W-1:0] ZONE_ASCII  = 4'h3;
  localparam logic [NIB_W-1:0] ZONE_EBCDIC = 4'hF;
  localparam logic [NIB_W-1:0] DIGIT_MAX   = 4'h9;

  typedef struct packed {
    logic              err;
    logic              last;
    logic [BYTE_W-1:0] data;
  } beat_t;

  function automatic logic bad_digit(input logic [NIB_W-1:0] d);
    return d > DIGIT_MAX;
  endfunction
endpackage

// File: rtl/dec_packer.sv
module dec_packer
  import dec_conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              emit_o,
  output beat_t             beat_o,
  output logic              busy_o
);
  logic             first_q, half_q, half_bad_q;
  logic [NIB_W-1:0] half_d_q;
  logic [NIB_W-1:0] digit, zone, sign_c;

  assign digit  = data_i[NIB_W-1:0];
  assign zone   = data_i[BYTE_W-1:NIB_W];
  assign sign_c = (zone == SIGN_MINUS || zone == SIGN_MINUS2) ? SIGN_MINUS : SIGN_PLUS;
  assign busy_o = !first_q;

  always_comb begin
    emit_o      = 1'b1;
    beat_o.last = last_i;
    if (first_q) begin
      beat_o.data = {digit, sign_c};
      beat_o.err  = bad_digit(digit);
    end else if (half_q) begin
      beat_o.data = {digit, half_d_q};
      beat_o.err  = bad_digit(digit) | half_bad_q;
    end else begin
      // lone digit: emitted only as zero-padded top byte
      emit_o      = last_i;
      beat_o.data = {{NIB_W{1'b0}}, digit};
      beat_o.err  = bad_digit(digit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q    <= 1'b1;
      half_q     <= 1'b0;
      half_bad_q <= 1'b0;
      half_d_q   <= '0;
    end else if (adv_i) begin
      if (first_q) begin
        first_q <= last_i;
        half_q  <= 1'b0;
      end else if (half_q) begin
        half_q  <= 1'b0;
        first_q <= last_i;
      end else if (last_i) begin
        first_q <= 1'b1;
      end else begin
        half_q     <= 1'b1;
        half_d_q   <= digit;
        half_bad_q <= bad_digit(digit);
      end
    end
  end

  // R2: frame-opening byte always carries a generated sign code
  a_r2_sign_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && first_q |-> (beat_o.data[NIB_W-1:0] == SIGN_PLUS || beat_o.data[NIB_W-1:0] == SIGN_MINUS));
  // R3: an unpaired middle digit is held for the next byte
  a_r3_half_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !first_q && !half_q && !last_i |=> half_q && !first_q);
  // R4: pending digit never survives a frame end
  a_r4_no_stale_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && last_i |=> !half_q && first_q);
endmodule

// File: rtl/dec_unpacker.sv
module dec_unpacker
  import dec_conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ebcdic_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              last_i,
  output logic              take_o,
  output beat_t             beat_o,
  output logic              busy_o
);
  logic             first_q, phase_q, mode_q;
  logic [NIB_W-1:0] zone, nib;

  assign take_o = first_q | phase_q;
  assign busy_o = !first_q;
  assign zone   = mode_q ? ZONE_EBCDIC : ZONE_ASCII;
  assign nib    = phase_q ? data_i[BYTE_W-1:NIB_W] : data_i[NIB_W-1:0];

  always_comb begin
    if (first_q) begin
      beat_o.data = {data_i[NIB_W-1:0], data_i[BYTE_W-1:NIB_W]};
      beat_o.err  = bad_digit(data_i[BYTE_W-1:NIB_W]);
      beat_o.last = last_i;
    end else begin
      beat_o.data = {zone, nib};
      beat_o.err  = bad_digit(nib);
      beat_o.last = phase_q & last_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      phase_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (step_i) begin
      if (first_q) begin
        first_q <= last_i;
        mode_q  <= ebcdic_i;
        phase_q <= 1'b0;
      end else if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        first_q <= last_i;
      end
    end
  end

  // R7: low nibble is always followed by the high nibble of the same byte
  a_r7_phase_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !first_q && !phase_q |=> phase_q && !first_q);
  // R5: low-nibble beat can never close a frame
  a_r5_low_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !first_q && !phase_q |-> !beat_o.last);
  // R8: mode held across the frame body
  a_r8_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_q && !(step_i && phase_q && last_i) |=> $stable(mode_q));
endmodule

// File: rtl/dec_out_reg.sv
module dec_out_reg
  import dec_conv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  ready_i,
  input  beat_t beat_i,
  output logic  open_o,
  output logic  valid_o,
  output beat_t beat_o
);
  assign open_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      beat_o  <= '0;
    end else if (open_o) begin
      valid_o <= load_i;
      if (load_i) beat_o <= beat_i;
    end
  end

  // R11: stalled beat must not change or vanish
  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(beat_o));
endmodule

// File: rtl/dec_conv.sv
module dec_conv
  import dec_conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              ebcdic_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              out_err_o
);
  logic  open, fire, sel_unp;
  logic  pk_emit, pk_busy, up_take, up_busy;
  beat_t pk_beat, up_beat, nxt_beat, out_beat;

  // a frame in flight owns the datapath; otherwise dir_i picks
  assign sel_unp    = up_busy | (!pk_busy & dir_i);
  assign fire       = in_valid_i & open;
  assign in_ready_o = open & (sel_unp ? up_take : 1'b1);
  assign nxt_beat   = sel_unp ? up_beat : pk_beat;

  dec_packer u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fire & !sel_unp),
    .data_i (in_data_i),
    .last_i (in_last_i),
    .emit_o (pk_emit),
    .beat_o (pk_beat),
    .busy_o (pk_busy)
  );

  dec_unpacker u_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (fire & sel_unp),
    .ebcdic_i (ebcdic_i),
    .data_i   (in_data_i),
    .last_i   (in_last_i),
    .take_o   (up_take),
    .beat_o   (up_beat),
    .busy_o   (up_busy)
  );

  dec_out_reg u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire & (sel_unp | pk_emit)),
    .ready_i (out_ready_i),
    .beat_i  (nxt_beat),
    .open_o  (open),
    .valid_o (out_valid_o),
    .beat_o  (out_beat)
  );

  assign out_data_o = out_beat.data;
  assign out_last_o = out_beat.last;
  assign out_err_o  = out_beat.err;

  // R8: never both directions mid-frame
  a_r8_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pk_busy && up_busy));
  // R11: input never accepted while output is blocked
  a_r11_no_accept_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
endmodule

// File: tb/dec_conv_tb_top.sv
module dec_conv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir = 1'b0, ebc = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_last, out_err;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  dec_conv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .ebcdic_i(ebc),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last), .out_err_o(out_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic stall_en = 1'b0;
  logic [7:0] in_b [16];
  logic [9:0] exp_b [64];
  int exp_n;
  logic [9:0] rx_b [64];
  int rx_n = 0;
  logic       held_v = 1'b0;
  logic [9:0] held_b;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    #2;
    if (held_v && out_valid)  // R11 stalled beat must be unchanged
      check({out_err, out_last, out_data} == held_b, "R11", {out_err, out_last, out_data}, held_b);
    held_v = out_valid && !out_ready;
    held_b = {out_err, out_last, out_data};
    if (out_valid && out_ready && rx_n < 64) begin
      rx_b[rx_n] = {out_err, out_last, out_data};
      rx_n++;
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  function automatic logic bd(input logic [3:0] d);
    return d > 4'h9;
  endfunction

  function automatic void push(input logic [7:0] b, input logic e);
    exp_b[exp_n] = {e, 1'b0, b};
    exp_n++;
  endfunction

  // expected output built from the requirement text
  function automatic void model(input logic d, input logic e, input int n);
    logic [3:0] s, z;
    exp_n = 0;
    if (!d) begin
      s = (in_b[0][7:4] == 4'hD || in_b[0][7:4] == 4'hB) ? 4'hD : 4'hC;
      push({in_b[0][3:0], s}, bd(in_b[0][3:0]));
      for (int j = 1; j < n; j += 2) begin
        if (j + 1 < n) push({in_b[j+1][3:0], in_b[j][3:0]}, bd(in_b[j+1][3:0]) | bd(in_b[j][3:0]));
        else push({4'h0, in_b[j][3:0]}, bd(in_b[j][3:0]));
      end
    end else begin
      z = e ? 4'hF : 4'h3;
      push({in_b[0][3:0], in_b[0][7:4]}, bd(in_b[0][7:4]));
      for (int j = 1; j < n; j++) begin
        push({z, in_b[j][3:0]}, bd(in_b[j][3:0]));
        push({z, in_b[j][7:4]}, bd(in_b[j][7:4]));
      end
    end
    exp_b[exp_n-1][8] = 1'b1;
  endfunction

  task automatic run(input string req, input logic d, input logic e, input int n, input bit flip);
    int t;
    model(d, e, n);
    rx_n = 0;
    @(negedge clk);
    dir = d; ebc = e;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = in_b[i]; in_last = (i == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      if (flip && i == 0) begin dir = ~d; ebc = ~e; end
    end
    in_valid = 1'b0; in_last = 1'b0;
    t = 0;
    while (rx_n < exp_n && t < 300) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    check(rx_n == exp_n, {req, " count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      check(rx_b[i] == exp_b[i], req, rx_b[i], exp_b[i]);
    dir = 1'b0; ebc = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(out_valid == 1'b0, "R1 valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
  endtask

  task automatic t_pack_odd;  // R2 R3 R5: 3 digits, plus
    in_b[0] = 8'h33; in_b[1] = 8'h32; in_b[2] = 8'h31;
    run("R2 R3 R5 pack odd", 1'b0, 1'b0, 3, 1'b0);
  endtask

  task automatic t_pack_even;  // R4: pad digit, minus D
    in_b[0] = 8'hD4; in_b[1] = 8'hF3; in_b[2] = 8'hF2; in_b[3] = 8'hF1;
    run("R4 pack even", 1'b0, 1'b0, 4, 1'b0);
  endtask

  task automatic t_pack_alt_minus;  // R2: zone B is minus, zone A plus
    in_b[0] = 8'hB7;
    run("R2 zone B", 1'b0, 1'b0, 1, 1'b0);
    in_b[0] = 8'hA5; in_b[1] = 8'h36;
    run("R2 zone A", 1'b0, 1'b0, 2, 1'b0);
  endtask

  task automatic t_unpack_ascii;  // R6 R7
    in_b[0] = 8'h5C; in_b[1] = 8'h34;
    run("R6 R7 unpack ascii", 1'b1, 1'b0, 2, 1'b0);
  endtask

  task automatic t_unpack_ebcdic_stall;  // R7 R11
    stall_en = 1'b1;
    in_b[0] = 8'h9D; in_b[1] = 8'h87; in_b[2] = 8'h21;
    run("R7 R11 unpack ebcdic", 1'b1, 1'b1, 3, 1'b0);
    stall_en = 1'b0;
  endtask

  task automatic t_err;  // R10
    in_b[0] = 8'h3A; in_b[1] = 8'h31;
    run("R10 pack err", 1'b0, 1'b0, 2, 1'b0);
    in_b[0] = 8'h1C; in_b[1] = 8'hB2;
    run("R10 unpack err", 1'b1, 1'b0, 2, 1'b0);
  endtask

  task automatic t_flip;  // R8: mid-frame dir/mode change ignored
    in_b[0] = 8'h5C; in_b[1] = 8'h34; in_b[2] = 8'h78;
    run("R8 unpack flip", 1'b1, 1'b0, 3, 1'b1);
    in_b[0] = 8'h39; in_b[1] = 8'h38; in_b[2] = 8'h37; in_b[3] = 8'h36;
    run("R8 pack flip", 1'b0, 1'b1, 4, 1'b1);
  endtask

  task automatic t_mode_pack;  // R9: ebcdic has no effect on packing
    in_b[0] = 8'h33; in_b[1] = 8'h32; in_b[2] = 8'h31;
    run("R9 pack ebcdic", 1'b0, 1'b1, 3, 1'b0);
  endtask

  task automatic t_stall_pack;  // R11 R5 long frame under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 9; i++) in_b[i] = 8'hF0 | 4'(i);
    run("R11 pack stall", 1'b0, 1'b0, 9, 1'b0);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pack_odd();
    t_pack_even();
    t_pack_alt_minus();
    t_unpack_ascii();
    t_unpack_ebcdic_stall();
    t_err();
    t_flip();
    t_mode_pack();
    t_stall_pack();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule